// File: doc/BRIEF.md
# Four-Way Data Cache Controller

This block sits between a 32-bit processor load/store port and a memory port that moves one word per handshake. It holds 16KB of data as 128 sets of four ways, each line eight words long. A lookup compares the request's tag against all four ways of the indexed set. A read hit or a write-back write hit completes in the same cycle with no memory traffic. On a miss the processor stalls while the controller writes back any modified part of the victim line and then refills the whole line.

Each line has one valid bit and two modified bits: one for words 0-3 and one for words 4-7. Only the modified halves are written back. The write policy is chosen per access. Write-through sends every store to memory and never allocates on a store miss. Write-back keeps stores in the cache and allocates on a store miss. The victim is an invalid way if one exists. Otherwise it comes from a per-set rotating pointer or from a free-running counter, selected by an input.

The processor raises `cpu_req` and holds the request fields steady until `cpu_ready` is high for one cycle. The memory side holds `mem_req`, direction, address and write data until `mem_ack` accepts the beat.

Top module: `dcache_ctrl`

## Requirements
- R1: After reset no line is valid, `cpu_ready` and `mem_req` are low, and the first access to any address misses and refills.
- R2: A read hit raises `cpu_ready` with the stored word on `cpu_rdata` and issues no memory beat.
- R3: A refill reads eight beats at word addresses line base + 0 through + 7, in ascending order. `cpu_ready` stays low until all eight beats are accepted.
- R4: While a set still has an invalid way, a miss fills that way. Four different tags that map to one set therefore all stay resident and later hit.
- R5: With `repl_rr`=1, each set has a pointer that advances by one on every refill of that set and names the victim when all ways are valid. Lines in a full set are therefore replaced in the order they were loaded.
- R6: With `repl_rr`=0, a miss in a full set replaces exactly one resident line, and the new line then hits.
- R7: A store with `cpu_wb`=0 performs one memory write beat carrying the request's address and data, and completes on that beat's acknowledge. If the line is present, its cached copy is updated too.
- R8: A store miss with `cpu_wb`=0 does not allocate: a later read of that address misses and refills.
- R9: A store hit with `cpu_wb`=1 issues no memory beat, and the stored word is read back from the cache.
- R10: A store miss with `cpu_wb`=1 refills the line (eight read beats, no writes) and then merges the word, so a following read hits and returns it.
- R11: When a valid line is evicted, each modified half is written back as four ascending beats before the refill starts. The lower half (words 0-3) goes first. A clean half produces no beats.
- R12: While a memory beat waits for `mem_ack`, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged.
- R13: Every read returns the last value the processor stored to that address, under any mix of policies, replacement modes and memory wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Access request, held until ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address (word aligned) |
| cpu_wdata | input | 32 | Store data |
| cpu_wb | input | 1 | 1 = write-back policy, 0 = write-through |
| repl_rr | input | 1 | 1 = rotating victim pointer, 0 = counter-based pseudo-random |
| cpu_rdata | output | 32 | Load data, valid with ready |
| cpu_ready | output | 1 | Access completes this cycle |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 32 | Write beat data |
| mem_rdata | input | 32 | Read beat data |
| mem_ack | input | 1 | Beat accepted this cycle |

## Verification
The hardest state to reach from the ports is an eviction whose victim has exactly one half, both halves, or neither half modified. It also has to come from a pointer that has already wrapped. The bench builds this deliberately in a four-set configuration. It fills a set through its invalid ways so that the rotating pointer wraps back to way 0. It then stores in write-back mode into the lower half of one line, the upper half of a second, both halves of a third, and neither half of the fourth. Four conflicting loads then evict those lines in load order, and the logged write-back addresses are compared with each line's modified halves. A long pseudo-random sweep with stretched acknowledges mixes both policies and both replacement modes. Each load result is compared with a shadow copy of every store.

// File: rtl/dcache_ctrl.sv
module dcache_ctrl #(
  parameter int SETS  = 128,
  parameter int WAYS  = 4,
  parameter int WORDS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  input  logic        cpu_wb,
  input  logic        repl_rr,
  output logic [31:0] cpu_rdata,
  output logic        cpu_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack
);
  localparam int OW = $clog2(WORDS);
  localparam int IW = $clog2(SETS);
  localparam int WW = $clog2(WAYS);
  localparam int TW = 30 - OW - IW;
  localparam int HW = OW - 1;

  typedef enum logic [1:0] {IDLE, EVICT, FILL, THRU} st_t;
  st_t st;

  logic [TW-1:0]   tags [WAYS][SETS];
  logic [31:0]     dat  [WAYS][SETS*WORDS];
  logic [1:0]      drt  [WAYS][SETS];
  logic [SETS-1:0] vld  [WAYS];
  logic [WW-1:0]   rrp  [SETS];
  logic [WW-1:0]   rnd, vway, hway, vic;
  logic [OW-1:0]   beat;
  logic [1:0]      vd;
  logic [WAYS-1:0] hitv;

  wire [IW-1:0] set = cpu_addr[OW+2 +: IW];
  wire [OW-1:0] off = cpu_addr[2 +: OW];
  wire [TW-1:0] tag = cpu_addr[31 -: TW];
  wire hit   = |hitv;
  wire hsel  = ~vd[0];
  wire lastb = (st == EVICT) ? &beat[HW-1:0] : &beat;
  wire wbhit = st == IDLE && cpu_req && cpu_we && cpu_wb && hit;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitv[w] = vld[w][set] && tags[w][set] == tag;
  end

  always_comb begin
    hway = '0;
    for (int w = 0; w < WAYS; w++)
      if (hitv[w]) hway = WW'(w);
  end

  always_comb begin
    vic = repl_rr ? rrp[set] : rnd;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld[w][set]) vic = WW'(w);
  end

  assign cpu_ready = (st == IDLE && cpu_req && hit && (!cpu_we || cpu_wb)) ||
                     (st == THRU && mem_ack);
  assign cpu_rdata = dat[hway][{set, off}];
  assign mem_req   = st != IDLE;
  assign mem_we    = st == EVICT || st == THRU;
  assign mem_wdata = (st == THRU) ? cpu_wdata : dat[vway][{set, hsel, beat[HW-1:0]}];

  always_comb begin
    case (st)
      EVICT:   mem_addr = {tags[vway][set], set, hsel, beat[HW-1:0], 2'b00};
      FILL:    mem_addr = {tag, set, beat, 2'b00};
      default: mem_addr = cpu_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (wbhit) begin
      dat[hway][{set, off}] <= cpu_wdata;
      drt[hway][set][off[OW-1]] <= 1'b1;
    end
    if (st == THRU && mem_ack && hit)
      dat[hway][{set, off}] <= cpu_wdata;
    if (st == FILL && mem_ack) begin
      dat[vway][{set, beat}] <= mem_rdata;
      if (lastb) begin
        tags[vway][set] <= tag;
        drt[vway][set]  <= 2'b00;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= IDLE;
      rnd  <= '0;
      vway <= '0;
      beat <= '0;
      vd   <= '0;
      for (int w = 0; w < WAYS; w++) vld[w] <= '0;
      for (int s = 0; s < SETS; s++) rrp[s] <= '0;
    end else begin
      rnd <= rnd + 1'b1;
      case (st)
        IDLE: if (cpu_req) begin
          if (cpu_we && !cpu_wb) st <= THRU;
          else if (!hit) begin
            vway <= vic;
            vd   <= vld[vic][set] ? drt[vic][set] : 2'b00;
            beat <= '0;
            st   <= (vld[vic][set] && drt[vic][set] != 2'b00) ? EVICT : FILL;
          end
        end
        EVICT: if (mem_ack) begin
          beat <= lastb ? '0 : beat + 1'b1;
          if (lastb) begin
            vd[hsel] <= 1'b0;
            if ((vd & ~(2'b01 << hsel)) == 2'b00) st <= FILL;
          end
        end
        FILL: if (mem_ack) begin
          beat <= beat + 1'b1;
          if (lastb) begin
            vld[vway][set] <= 1'b1;
            rrp[set] <= rrp[set] + 1'b1;
            st <= IDLE;
          end
        end
        THRU: if (mem_ack) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcache_ctrl_chk.sv
module dcache_ctrl_chk #(
  parameter int WAYS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_req,
  input logic            cpu_we,
  input logic            cpu_wb,
  input logic            cpu_ready,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_ack,
  input logic [31:0]     mem_addr,
  input logic [31:0]     mem_wdata,
  input logic [WAYS-1:0] hitv
);
  a_r12_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

  a_r7_thru_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && cpu_we && !cpu_wb |-> mem_req && mem_we && mem_ack);

  a_r2_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && !cpu_we |-> !mem_req);

  a_r9_store_local: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && cpu_we && cpu_wb |-> !mem_req);

  a_r3_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req);

  a_r13_single_way: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hitv));
endmodule

bind dcache_ctrl dcache_ctrl_chk #(.WAYS(WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_wb(cpu_wb),
  .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .hitv(hitv)
);

// File: tb/dcache_ctrl_test.sv
`timescale 1ns/1ps
module dcache_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0, cpu_wb = 0, repl_rr = 1;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0, cpu_rdata, mem_addr, mem_wdata, mem_rdata;
  logic cpu_ready, mem_req, mem_we, mem_ack, ack_en = 1, slow = 0;

  dcache_ctrl #(.SETS(4), .WAYS(4), .WORDS(8)) uut (.*);

  always #2.5 clk = ~clk;

  logic [31:0] mem    [logic [31:0]];
  logic [31:0] shadow [logic [31:0]];
  logic [31:0] wlog [16];
  int nchk = 0, fails = 0;
  int rbeats = 0, wbeats = 0, wi = 0, ri = 0, wfirst = 0, dr = 0, dw = 0, cyc = 0, stab_bad = 0;
  logic hold = 0, pw = 0;
  logic [31:0] pa = 0, pd = 0, q;

  function automatic logic [31:0] dflt(input logic [31:0] a);
    return {a[15:0] ^ 16'h5a3c, a[31:16] ^ a[15:0]};
  endfunction
  function automatic logic [31:0] mrd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : dflt(a);
  endfunction
  function automatic logic [31:0] expv(input logic [31:0] a);
    return shadow.exists(a) ? shadow[a] : dflt(a);
  endfunction
  function automatic logic [31:0] mk(input int t, input int s, input int w);
    return (32'(t) << 7) | (32'(s) << 5) | (32'(w) << 2);
  endfunction

  assign mem_ack = mem_req & ack_en;
  always @(mem_addr or wbeats) mem_rdata = mrd(mem_addr);

  always @(posedge clk) begin
    cyc++;
    ack_en <= !slow || (cyc % 3 != 0);
    if (rst_n) begin
      if (hold && (!mem_req || mem_addr !== pa || mem_we !== pw || mem_wdata !== pd)) stab_bad++;
      hold = mem_req && !mem_ack;
      pa = mem_addr; pw = mem_we; pd = mem_wdata;
      if (mem_req && mem_ack) begin
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          if (wi < 16) wlog[wi] = mem_addr;
          wi++; wbeats++;
        end else begin
          if (ri == 0) wfirst = wi;
          ri++; rbeats++;
        end
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act %h exp %h", r, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [31:0] a, input logic [31:0] d, input logic wb);
    int rb0, wb0, n;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_wb = wb;
    rb0 = rbeats; wb0 = wbeats; wi = 0; ri = 0; wfirst = 0; n = 0;
    forever begin
      #1;
      if (cpu_ready) begin q = cpu_rdata; break; end
      n++;
      if (n > 200) begin chk("R13 stall", 0, 1); break; end
      @(negedge clk);
    end
    @(posedge clk); #1;
    cpu_req = 0;
    dr = rbeats - rb0; dw = wbeats - wb0;
    if (we) shadow[a] = d;
  endtask

  task automatic rd(input logic [31:0] a, input string r);
    acc(0, a, 0, 0);
    chk(r, q, expv(a));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R13 watchdog act hung exp done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, fails);
    $finish;
  end

  initial begin
    logic [31:0] s;
    int found;
    repeat (3) @(negedge clk);
    chk("R1 ready after reset", cpu_ready, 0);
    chk("R1 mem_req after reset", mem_req, 0);
    rst_n = 1;
    // R1 R3: cold miss refills from word 0
    rd(mk(1,0,3), "R1 data");
    chk("R1 refill beats", dr, 8);
    chk("R3 no writes", dw, 0);
    for (int k = 0; k < 8; k++) begin
      acc(0, mk(1,0,k), 0, 0);
      chk("R2 hit no traffic", dr, 0);
      chk("R2 hit data", q, expv(mk(1,0,k)));
    end
    // R4: invalid ways fill first
    for (int t = 2; t <= 4; t++) begin rd(mk(t,0,t), "R4 data"); chk("R4 fill", dr, 8); end
    for (int t = 1; t <= 4; t++) begin rd(mk(t,0,0), "R4 data"); chk("R4 resident", dr, 0); end
    // R5: rotating pointer replaces in load order
    rd(mk(5,0,1), "R5 data"); chk("R5 refill", dr, 8);
    for (int t = 2; t <= 5; t++) begin rd(mk(t,0,2), "R5 data"); chk("R5 survivors hit", dr, 0); end
    rd(mk(1,0,4), "R5 data"); chk("R5 oldest evicted", dr, 8);
    rd(mk(3,0,4), "R5 data"); chk("R5 third kept", dr, 0);
    rd(mk(2,0,4), "R5 data"); chk("R5 second evicted", dr, 8);
    // R9 R11: write-back and half-line eviction in set 1
    for (int t = 1; t <= 4; t++) rd(mk(t,1,0), "R11 data");
    acc(1, mk(1,1,1), 32'h1111_0001, 1); chk("R9 no reads", dr, 0); chk("R9 no writes", dw, 0);
    rd(mk(1,1,1), "R9 readback"); chk("R9 hit", dr, 0);
    acc(1, mk(2,1,6), 32'h2222_0006, 1);
    acc(1, mk(3,1,2), 32'h3333_0002, 1);
    acc(1, mk(3,1,7), 32'h3333_0007, 1);
    rd(mk(5,1,0), "R11 data");
    chk("R11 low half beats", dw, 4); chk("R11 refill", dr, 8); chk("R11 wb before fill", wfirst, 4);
    for (int k = 0; k < 4; k++) chk("R11 low addr", wlog[k], mk(1,1,k));
    chk("R11 low mem", mrd(mk(1,1,1)), 32'h1111_0001);
    rd(mk(6,1,0), "R11 data");
    chk("R11 high half beats", dw, 4);
    for (int k = 0; k < 4; k++) chk("R11 high addr", wlog[k], mk(2,1,4+k));
    chk("R11 high mem", mrd(mk(2,1,6)), 32'h2222_0006);
    rd(mk(7,1,0), "R11 data");
    chk("R11 both halves", dw, 8); chk("R11 both first", wfirst, 8);
    for (int k = 0; k < 8; k++) chk("R11 both addr", wlog[k], mk(3,1,k));
    rd(mk(8,1,0), "R11 data"); chk("R11 clean none", dw, 0);
    // R10: write-back store miss allocates
    acc(1, mk(1,2,5), 32'hCAFE_0005, 1); chk("R10 refill", dr, 8); chk("R10 no write", dw, 0);
    rd(mk(1,2,5), "R10 merged"); chk("R10 hit", dr, 0);
    // R7 R8: write-through
    acc(1, mk(1,3,2), 32'hBEEF_0002, 0);
    chk("R7 one beat", dw, 1); chk("R7 no read", dr, 0);
    chk("R7 addr", wlog[0], mk(1,3,2)); chk("R7 mem", mrd(mk(1,3,2)), 32'hBEEF_0002);
    rd(mk(1,3,2), "R8 data"); chk("R8 no allocate", dr, 8);
    acc(1, mk(1,3,3), 32'hBEEF_0003, 0); chk("R7 hit beat", dw, 1); chk("R7 hit no read", dr, 0);
    rd(mk(1,3,3), "R7 cached copy"); chk("R7 still hit", dr, 0);
    // R6: pseudo-random replacement in set 2
    repl_rr = 0;
    for (int t = 2; t <= 4; t++) begin rd(mk(t,2,0), "R6 data"); chk("R4 invalid first", dr, 8); end
    rd(mk(9,2,3), "R6 data"); chk("R6 refill", dr, 8);
    rd(mk(9,2,3), "R6 data"); chk("R6 new line hits", dr, 0);
    found = 0;
    for (int t = 1; t <= 4; t++) begin
      rd(mk(t,2,5), "R6 data");
      if (dr != 0) begin found = 1; break; end
    end
    chk("R6 one replaced", found, 1);
    // R13 R12: mixed sweep with stretched acknowledges
    slow = 1;
    s = 32'h1234_5678;
    for (int i = 0; i < 1500; i++) begin
      s = s * 32'd1103515245 + 32'd12345;
      repl_rr = s[19];
      if (s[17]) begin
        acc(1, mk(int'(s[10:8]) % 6 + 1, int'(s[13:12]), int'(s[16:14])), s ^ 32'h0f0f_0000, s[18]);
        if (!s[18]) chk("R7 sweep mem", mrd(cpu_addr), cpu_wdata);
      end else
        rd(mk(int'(s[10:8]) % 6 + 1, int'(s[13:12]), int'(s[16:14])), "R13 sweep");
    end
    chk("R12 beat hold", stab_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, fails);
    $finish;
  end
endmodule